// File: doc/BRIEF.md
# Memory Port Arbiter with Block-Copy Sequencer

This block owns the single main-memory port of a small processor. Three core-side requesters share it: data reads issued by the execution stage, instruction fetches, and drained write-buffer stores. A block-copy engine can also take the port. The arbiter serves one access at a time. It picks the winner by a fixed ranking, presents the winner's address and direction to memory, and keeps them there until memory signals ready. It then reports completion to that requester and arbitrates again.

The copy engine takes a source address, a destination address and a byte count. It keeps the port for the whole copy. On each beat the source address is shown on the normal address bus as a read. At the same time the destination address is shown on a separate transfer bus with its own strobe. The memory system acknowledges each byte. After an acknowledge, both addresses step forward and the count steps down. A busy flag tells the core that the copy is running.

A requester raises its request line and keeps it high, with a steady address, until it sees its completion pulse. A copy command is accepted only while the port is free. The commander keeps it high until the busy flag rises.

Top module: `mem_arb_dma`

## Requirements
- R1: While reset is held, `mem_req`, `xfer_req`, `dma_busy`, all grants and all completion pulses are 0.
- R2: When several core requests are pending and the port is free, the order of service is data read (index 0) first, then fetch (index 1), then write (index 2).
- R3: If a copy command with a non-zero count and a core request are both present at the same free-port edge, the copy wins. The core request is served after the copy ends.
- R4: During a core access, `mem_req` is 1. `mem_addr` carries the winner's address, latched at grant. `mem_rd` is 1 for read and fetch and 0 for write. Address, direction and grant stay unchanged until the edge at which `mem_rdy` is sampled high.
- R5: The edge that samples `mem_rdy` high ends the access. For the next cycle, the requester's completion pulse is 1 and `mem_req` is 0. The next grant can appear no earlier than the cycle after that.
- R6: On each copy beat, `mem_req`=1, `mem_rd`=1, `mem_addr` shows the current source and `xfer_req`=1 with `xfer_addr` showing the current destination. While `xfer_ack` is 0, both addresses hold. Each acknowledged beat adds 1 to both addresses.
- R7: `dma_busy` rises one cycle after the command is accepted. It stays 1 for exactly as many acknowledged beats as the count, and it is 0 in the cycle after the last acknowledge.
- R8: A copy command with a count of 0 is finished at once. No busy cycle, no memory request and no transfer request follow from it.
- R9: A copy never preempts a core access in progress. Core requests raised during a copy get no grant until it ends. A copy command raised during a copy is ignored.
- R10: Source and destination addresses wrap modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Data-read request from execution |
| rd_addr | input | ADDR_W | Data-read address |
| rd_gnt | output | 1 | Port is serving the data read |
| rd_done | output | 1 | Data-read completion pulse |
| fetch_req | input | 1 | Instruction-fetch request |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_gnt | output | 1 | Port is serving the fetch |
| fetch_done | output | 1 | Fetch completion pulse |
| wr_req | input | 1 | Write-buffer drain request |
| wr_addr | input | ADDR_W | Write address |
| wr_gnt | output | 1 | Port is serving the write |
| wr_done | output | 1 | Write completion pulse |
| dma_go | input | 1 | Copy command |
| dma_src | input | ADDR_W | Copy source start address |
| dma_dst | input | ADDR_W | Copy destination start address |
| dma_len | input | CNT_W | Copy byte count |
| dma_busy | output | 1 | Copy in progress |
| mem_req | output | 1 | Memory request strobe |
| mem_addr | output | ADDR_W | Memory address (copy source during a copy) |
| mem_rd | output | 1 | 1 = read, 0 = write |
| mem_rdy | input | 1 | Memory ready for the current core access |
| xfer_req | output | 1 | Copy transfer strobe |
| xfer_addr | output | ADDR_W | Copy destination address |
| xfer_ack | input | 1 | Memory system takes the current copy byte |

## Verification
A core request driven before an edge shows its grant, address and direction right after that edge, because only the state register lies in the path. The completion pulse appears right after the edge that samples `mem_rdy`, together with a dropped `mem_req`. The next grant follows one edge later. A copy command makes `dma_busy` visible after the accepting edge, and each acknowledged beat changes the addresses after the edge that samples `xfer_ack`. The bench drives every input on the falling edge and samples on the following falling edge, so each check lands in the cycle where its result is due. Stall cycles are inserted to confirm that nothing moves while ready or acknowledge is low.

// File: rtl/mad_pkg.sv
package mad_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CORE = 2'd1,
    ST_DMA  = 2'd2
  } port_state_t;

  localparam int N_CORE   = 3;
  localparam int IDX_RD   = 0;
  localparam int IDX_FET  = 1;
  localparam int IDX_WR   = 2;
  // bit set = that source reads memory
  localparam logic [N_CORE-1:0] READ_MASK = 3'b011;
endpackage

// File: rtl/mad_prio_pick.sv
module mad_prio_pick #(
  parameter int N = 3
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick_oh,
  output logic         pick_any
);
  // index 0 has the highest rank
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_rank
      if (i == 0) begin : g_top
        assign pick_oh[i] = req[i];
      end else begin : g_rest
        assign pick_oh[i] = req[i] & ~(|req[i-1:0]);
      end
    end
  endgenerate

  assign pick_any = |req;
endmodule

// File: rtl/mad_dma_seq.sv
module mad_dma_seq #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] src_in,
  input  logic [ADDR_W-1:0] dst_in,
  input  logic [CNT_W-1:0]  len_in,
  input  logic              beat,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic              last_beat
);
  logic [CNT_W-1:0] left_q;

  function automatic logic [ADDR_W-1:0] addr_step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      left_q <= '0;
    end else if (load) begin
      src_q  <= src_in;
      dst_q  <= dst_in;
      left_q <= len_in;
    end else if (beat) begin
      src_q  <= addr_step(src_q);
      dst_q  <= addr_step(dst_q);
      left_q <= cnt_step(left_q);
    end
  end

  assign last_beat = (left_q == CNT_W'(1));
endmodule

// File: rtl/mad_core_port.sv
module mad_core_port #(
  parameter int N      = 3,
  parameter int ADDR_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grant,
  input  logic [N-1:0]        pick_oh,
  input  logic [N*ADDR_W-1:0] addr_flat,
  input  logic                finish,
  output logic [N-1:0]        owner_q,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [N-1:0]        done_q
);
  function automatic logic [ADDR_W-1:0] oh_select(
    input logic [N-1:0] sel,
    input logic [N*ADDR_W-1:0] flat
  );
    logic [ADDR_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < N; k++) begin
      if (sel[k]) acc = acc | flat[k*ADDR_W +: ADDR_W];
    end
    return acc;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= '0;
      addr_q  <= '0;
      done_q  <= '0;
    end else begin
      done_q <= finish ? owner_q : '0;
      if (grant) begin
        owner_q <= pick_oh;
        addr_q  <= oh_select(pick_oh, addr_flat);
      end else if (finish) begin
        owner_q <= '0;
      end
    end
  end
endmodule

// File: rtl/mem_arb_dma.sv
module mem_arb_dma #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_gnt,
  output logic              rd_done,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_gnt,
  output logic              fetch_done,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_gnt,
  output logic              wr_done,
  input  logic              dma_go,
  input  logic [ADDR_W-1:0] dma_src,
  input  logic [ADDR_W-1:0] dma_dst,
  input  logic [CNT_W-1:0]  dma_len,
  output logic              dma_busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic              mem_rdy,
  output logic              xfer_req,
  output logic [ADDR_W-1:0] xfer_addr,
  input  logic              xfer_ack
);
  import mad_pkg::*;

  localparam int NC = N_CORE;

  port_state_t st_q, st_d;

  logic [NC-1:0]        core_req_v;
  logic [NC*ADDR_W-1:0] core_addr_flat;
  logic [NC-1:0]        pick_oh;
  logic                 pick_any;
  logic [NC-1:0]        owner_q;
  logic [NC-1:0]        done_q;
  logic [ADDR_W-1:0]    core_addr_q;
  logic [ADDR_W-1:0]    src_q;
  logic [ADDR_W-1:0]    dst_q;
  logic                 seq_last;

  // named internal events
  logic port_free;
  logic ev_dma_start;
  logic ev_core_grant;
  logic ev_core_finish;
  logic ev_dma_beat;
  logic ev_dma_end;

  assign core_req_v     = {wr_req, fetch_req, rd_req};
  assign core_addr_flat = {wr_addr, fetch_addr, rd_addr};

  assign port_free      = (st_q == ST_IDLE);
  assign ev_dma_start   = port_free && dma_go && (dma_len != '0);
  assign ev_core_grant  = port_free && !ev_dma_start && pick_any;
  assign ev_core_finish = (st_q == ST_CORE) && mem_rdy;
  assign ev_dma_beat    = (st_q == ST_DMA) && xfer_ack;
  assign ev_dma_end     = ev_dma_beat && seq_last;

  mad_prio_pick #(.N(NC)) u_pick (
    .req      (core_req_v),
    .pick_oh  (pick_oh),
    .pick_any (pick_any)
  );

  mad_core_port #(.N(NC), .ADDR_W(ADDR_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (ev_core_grant),
    .pick_oh   (pick_oh),
    .addr_flat (core_addr_flat),
    .finish    (ev_core_finish),
    .owner_q   (owner_q),
    .addr_q    (core_addr_q),
    .done_q    (done_q)
  );

  mad_dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_dma_start),
    .src_in    (dma_src),
    .dst_in    (dma_dst),
    .len_in    (dma_len),
    .beat      (ev_dma_beat),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .last_beat (seq_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ev_dma_start)       st_d = ST_DMA;
        else if (ev_core_grant) st_d = ST_CORE;
      end
      ST_CORE: if (ev_core_finish) st_d = ST_IDLE;
      ST_DMA:  if (ev_dma_end)     st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign dma_busy   = (st_q == ST_DMA);
  assign mem_req    = (st_q != ST_IDLE);
  assign mem_addr   = dma_busy ? src_q : core_addr_q;
  assign mem_rd     = dma_busy | (|(owner_q & READ_MASK));
  assign xfer_req   = dma_busy;
  assign xfer_addr  = dma_busy ? dst_q : '0;

  assign rd_gnt     = owner_q[IDX_RD];
  assign fetch_gnt  = owner_q[IDX_FET];
  assign wr_gnt     = owner_q[IDX_WR];
  assign rd_done    = done_q[IDX_RD];
  assign fetch_done = done_q[IDX_FET];
  assign wr_done    = done_q[IDX_WR];
endmodule

// File: rtl/mem_arb_dma_chk.sv
module mem_arb_dma_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_gnt,
  input logic              fetch_gnt,
  input logic              wr_gnt,
  input logic              rd_done,
  input logic              fetch_done,
  input logic              wr_done,
  input logic              dma_busy,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_rdy,
  input logic              xfer_req,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic              xfer_ack
);
  logic any_core_gnt;
  assign any_core_gnt = rd_gnt | fetch_gnt | wr_gnt;

  p_single_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_gnt, fetch_gnt, wr_gnt, dma_busy}));

  p_hold_until_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_core_gnt && !mem_rdy) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_rd) && $stable({rd_gnt, fetch_gnt, wr_gnt})));

  p_direction_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_core_gnt |-> (mem_rd == !wr_gnt));

  p_done_after_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_core_gnt && mem_rdy) |=>
      (!mem_req && ((rd_done | fetch_done | wr_done) == 1'b1)));

  p_done_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done || fetch_done || wr_done) |=> !(rd_done || fetch_done || wr_done));

  p_xfer_in_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req |-> (dma_busy && mem_req && mem_rd));

  p_copy_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_busy && !xfer_ack) |=>
      (dma_busy && $stable(mem_addr) && $stable(xfer_addr)));

  p_copy_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_busy && xfer_ack) |=>
      (!dma_busy || ((mem_addr == $past(mem_addr) + ADDR_W'(1)) &&
                     (xfer_addr == $past(xfer_addr) + ADDR_W'(1)))));

  p_no_preempt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_core_gnt && !mem_rdy) |=> !dma_busy);
endmodule

bind mem_arb_dma mem_arb_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_gnt     (rd_gnt),
  .fetch_gnt  (fetch_gnt),
  .wr_gnt     (wr_gnt),
  .rd_done    (rd_done),
  .fetch_done (fetch_done),
  .wr_done    (wr_done),
  .dma_busy   (dma_busy),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_rd     (mem_rd),
  .mem_rdy    (mem_rdy),
  .xfer_req   (xfer_req),
  .xfer_addr  (xfer_addr),
  .xfer_ack   (xfer_ack)
);

// File: tb/mem_arb_dma_tb.sv
module mem_arb_dma_tb;
  localparam int AW = 20;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 0, fetch_req = 0, wr_req = 0;
  logic [AW-1:0] rd_addr = '0, fetch_addr = '0, wr_addr = '0;
  logic rd_gnt, fetch_gnt, wr_gnt, rd_done, fetch_done, wr_done;
  logic dma_go = 0;
  logic [AW-1:0] dma_src = '0, dma_dst = '0;
  logic [CW-1:0] dma_len = '0;
  logic dma_busy, mem_req, mem_rd, xfer_req;
  logic [AW-1:0] mem_addr, xfer_addr;
  logic mem_rdy = 0, xfer_ack = 0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mem_arb_dma #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_gnt(rd_gnt), .rd_done(rd_done),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_gnt(fetch_gnt), .fetch_done(fetch_done),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_gnt(wr_gnt), .wr_done(wr_done),
    .dma_go(dma_go), .dma_src(dma_src), .dma_dst(dma_dst), .dma_len(dma_len), .dma_busy(dma_busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdy(mem_rdy),
    .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_ack(xfer_ack)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] gnt_v();
    return {wr_gnt, fetch_gnt, rd_gnt};
  endfunction

  function automatic logic [2:0] done_v();
    return {wr_done, fetch_done, rd_done};
  endfunction

  task automatic set_req(input int idx, input logic v, input logic [AW-1:0] a);
    case (idx)
      0: begin rd_req = v; rd_addr = a; end
      1: begin fetch_req = v; fetch_addr = a; end
      default: begin wr_req = v; wr_addr = a; end
    endcase
  endtask

  // grant becomes visible at the next falling edge
  task automatic serve_one(input int idx, input logic [AW-1:0] a, input int lat);
    logic [2:0] want;
    want = 3'(1 << idx);
    @(negedge clk);
    check(gnt_v() == want, "R2 grant order", 32'(gnt_v()), 32'(want));
    check(done_v() == 3'b000, "R5 done pulse width", 32'(done_v()), 0);
    check(mem_req && mem_addr == a, "R4 address", mem_addr, a);
    check(mem_rd == (idx != 2), "R4 direction", 32'(mem_rd), 32'(idx != 2));
    for (int w = 0; w < lat; w++) begin
      mem_rdy = 0;
      @(negedge clk);
      check(gnt_v() == want && mem_addr == a && mem_req, "R4 hold while not ready", mem_addr, a);
    end
    mem_rdy = 1;
    @(negedge clk);
    mem_rdy = 0;
    check(done_v() == want, "R5 completion", 32'(done_v()), 32'(want));
    check(!mem_req && gnt_v() == 3'b000, "R5 port released", 32'(mem_req), 0);
    set_req(idx, 0, a);
  endtask

  task automatic dma_run(input logic [AW-1:0] src, input logic [AW-1:0] dst, input int len,
                         input bit stall, input bit poke, input logic [2:0] also, input bit preset);
    logic [AW-1:0] es, ed;
    if (!preset) begin
      @(negedge clk);
      dma_src = src; dma_dst = dst; dma_len = CW'(len); dma_go = 1;
      if (also[0]) set_req(0, 1, 20'h0A0A0);
      if (also[1]) set_req(1, 1, 20'h0B0B0);
      if (also[2]) set_req(2, 1, 20'h0C0C0);
    end
    @(negedge clk);
    dma_go = 0;
    if (len == 0) begin
      for (int q = 0; q < 3; q++) begin
        check(!dma_busy && !mem_req && !xfer_req, "R8 zero count idle", 32'(dma_busy), 0);
        @(negedge clk);
      end
      return;
    end
    for (int k = 0; k < len; k++) begin
      es = src + AW'(k);
      ed = dst + AW'(k);
      check(dma_busy, "R7 busy during copy", 32'(dma_busy), 1);
      check(mem_req && mem_rd && mem_addr == es, "R6 source beat R10", mem_addr, es);
      check(xfer_req && xfer_addr == ed, "R6 dest beat R10", xfer_addr, ed);
      check(gnt_v() == 3'b000, "R9 no core grant in copy", 32'(gnt_v()), 0);
      if (stall && (k % 2 == 1)) begin
        xfer_ack = 0;
        @(negedge clk);
        check(mem_addr == es && xfer_addr == ed, "R6 stall holds", mem_addr, es);
      end
      if (poke && k == 1) begin
        dma_go = 1; dma_src = 20'h55555; dma_len = 10'd7;
      end
      xfer_ack = 1;
      @(negedge clk);
      xfer_ack = 0;
      dma_go = 0;
    end
    check(!dma_busy && !xfer_req && !mem_req, "R7 busy ends after count", 32'(dma_busy), 0);
  endtask

  initial begin : main
    // R1 reset
    repeat (2) @(negedge clk);
    check(!mem_req && !xfer_req && !dma_busy && gnt_v() == 0 && done_v() == 0,
          "R1 reset state", 32'(mem_req), 0);
    rst_n = 1;
    @(negedge clk);
    check(!mem_req && !dma_busy, "R1 after release", 32'(mem_req), 0);

    // R2 R4 R5 near-exhaustive sweep over request subsets and ready latencies
    for (int pat = 1; pat < 8; pat++) begin
      for (int lat = 0; lat < 3; lat++) begin
        logic [AW-1:0] base [3];
        base[0] = AW'(32'h10000 + pat * 16 + lat);
        base[1] = AW'(32'h20000 + pat * 16 + lat);
        base[2] = AW'(32'h30000 + pat * 16 + lat);
        for (int s = 0; s < 3; s++) if (pat[s]) set_req(s, 1, base[s]);
        for (int s = 0; s < 3; s++) if (pat[s]) serve_one(s, base[s], lat);
      end
    end

    // R6 R7 copies of several lengths, with and without stalls
    dma_run(20'h00100, 20'h00800, 1, 0, 0, 3'b000, 0);
    dma_run(20'h01000, 20'h02000, 2, 1, 0, 3'b000, 0);
    dma_run(20'h03000, 20'h04000, 5, 1, 0, 3'b000, 0);
    // R8 zero count
    dma_run(20'h05000, 20'h06000, 0, 0, 0, 3'b000, 0);
    // R10 wrap at the top of the address space
    dma_run(20'hFFFFE, 20'hFFFFF, 4, 1, 0, 3'b000, 0);
    // maximum count
    dma_run(20'h40000, 20'h80000, 1023, 0, 0, 3'b000, 0);

    // R9 new command during a copy is ignored
    dma_run(20'h07000, 20'h07800, 4, 0, 1, 3'b000, 0);
    @(negedge clk);
    check(!dma_busy && !mem_req, "R9 ignored command left no copy", 32'(dma_busy), 0);

    // R3 copy wins over simultaneous fetch; R9 fetch waits
    dma_run(20'h08000, 20'h09000, 3, 0, 0, 3'b010, 0);
    serve_one(1, 20'h0B0B0, 1);

    // R9 copy command during a core access waits for it
    @(negedge clk);
    set_req(2, 1, 20'h0C123);
    @(negedge clk);
    check(wr_gnt && !mem_rd, "R4 write granted", 32'(gnt_v()), 4);
    dma_src = 20'h0D000; dma_dst = 20'h0E000; dma_len = 10'd2; dma_go = 1;
    mem_rdy = 0;
    @(negedge clk);
    check(wr_gnt && !dma_busy && mem_addr == 20'h0C123, "R9 no preempt", 32'(dma_busy), 0);
    mem_rdy = 1;
    @(negedge clk);
    mem_rdy = 0;
    check(wr_done && !dma_busy, "R5 write done before copy", 32'(done_v()), 4);
    set_req(2, 0, 20'h0C123);
    dma_run(20'h0D000, 20'h0E000, 2, 0, 0, 3'b000, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule